// File: doc/BRIEF.md
# Eight-Channel Serial ADC Capture Controller

This block is the host-side master for a simultaneous-sampling converter that returns eight 18-bit results over a serial link. After a start request it drives the active-low chip select and a serial clock that idles high. It samples one or two serial data lines, MSB first, at each falling edge of the serial clock. It then moves the eight words into output registers, which all change in the same cycle, and raises a one-cycle done pulse.

Configuration is latched when a transfer starts. The options are:
- two lanes or one lane;
- in single-lane mode, which lane is used;
- one chip-select window for the whole transfer, or a separate window for each 18-clock word;
- the serial clock half-period, in system clock cycles.

During each transfer the controller checks the converter's first-word flag. A wrong level sets an alignment error that is reported together with done. The converter refreshes its result registers on the falling edge of its busy line. If that edge arrives during a transfer, the controller abandons the transfer, reports corruption and starts the read again.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, cs_n=1, sclk=1, done=0, align_err=0, corrupt=0 and ch_data is all zeros.
- R2: With cfg_single=0, one transfer issues exactly 72 sclk falling edges. Lane A words go to channels 1..4 and lane B words go to channels 5..8, in slot order. Each word is 18 bits, taken MSB first, one bit at each sclk falling edge.
- R3: With cfg_single=1 and cfg_lane_b=0, one transfer issues exactly 144 sclk falling edges on lane A. The words are stored as channels 1..8 in arrival order.
- R4: With cfg_single=1 and cfg_lane_b=1, the words on lane B arrive in the order 5,6,7,8,1,2,3,4. Each word is stored in the register of the channel it belongs to.
- R5: With cfg_frame_each=0, cs_n falls once per transfer. With cfg_frame_each=1, cs_n falls once per 18-bit word and goes high between words (4 falls with two lanes, 8 with one lane).
- R6: first_flag must be 1 at every sample of the first word slot and 0 at every later sample. Any mismatch sets align_err when done is asserted. align_err then holds until the next done.
- R7: If busy falls while a transfer is active, corrupt pulses for one cycle with cs_n high, and the transfer restarts from the first word. The results delivered are the data present after that busy edge.
- R8: The time between consecutive sclk falling edges inside one chip-select window is 2*cfg_half system cycles, with 0 treated as 1. The first sclk fall comes at least cfg_half cycles after cs_n falls.
- R9: done is a one-cycle pulse that occurs with cs_n high. All eight ch_data words change only in the cycle done is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer (taken when idle) |
| busy | input | 1 | Converter busy; falling edge refreshes its results |
| sdo_a | input | 1 | Serial data lane A |
| sdo_b | input | 1 | Serial data lane B |
| first_flag | input | 1 | Converter flag marking the first word slot |
| cfg_single | input | 1 | 1: read all words over one lane |
| cfg_lane_b | input | 1 | In single-lane mode, use lane B |
| cfg_frame_each | input | 1 | 1: separate chip-select window per word |
| cfg_half | input | DIV_W | Serial clock half-period in clk cycles (0 acts as 1) |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| done | output | 1 | One-cycle pulse when results are updated |
| align_err | output | 1 | First-word flag mismatch in the last completed transfer |
| corrupt | output | 1 | One-cycle pulse when a transfer is abandoned on a busy fall |
| ch_data | output | NCH*BITS | Channel words; channel k (k=1..8) at bits [(k-1)*BITS +: BITS] |

## Verification
Each result word has a distinct value, and the first word has both its MSB and its LSB set. A dropped bit, a shift by one bit or swapped lanes therefore shows up as a wrong word.

The same kind of data is read in three lane settings: two lanes, lane A alone and lane B alone. These runs separate correct channel placement from a controller that ignores the lane choice or skips the lane-B rotation. Runs that differ only in framing and half-period show whether the chip-select count and the clock spacing come from the configuration. A flag held low, and a busy fall injected in the middle of a transfer, drive the error path and the restart path; a following clean run shows that the error report clears.

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl #(
  parameter int BITS  = 18,
  parameter int NCH   = 8,
  parameter int DIV_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  busy,
  input  logic                  sdo_a,
  input  logic                  sdo_b,
  input  logic                  first_flag,
  input  logic                  cfg_single,
  input  logic                  cfg_lane_b,
  input  logic                  cfg_frame_each,
  input  logic [DIV_W-1:0]      cfg_half,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  done,
  output logic                  align_err,
  output logic                  corrupt,
  output logic [NCH*BITS-1:0]   ch_data
);
  localparam int HALF_CH = NCH / 2;
  localparam int SW = $clog2(NCH + 1);
  localparam int IW = $clog2(NCH);
  localparam int BW = $clog2(BITS);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_GAP, S_REST} st_t;

  st_t              st;
  logic [DIV_W-1:0] half_q, cnt;
  logic             single_q, laneb_q, frame_q, busy_q, err_q;
  logic [BW-1:0]    bitc;
  logic [SW-1:0]    slot;
  logic [BITS-1:0]  sh_a, sh_b;
  logic [BITS-1:0]  stage [NCH];

  wire             tick     = (cnt == half_q - 1'b1);
  wire             bfall    = busy_q & ~busy;
  wire [SW-1:0]    nslots   = single_q ? SW'(NCH) : SW'(HALF_CH);
  wire             slot_end = (bitc == '0) && (slot != '0);
  wire             last     = (slot == nslots);
  wire             do_samp  = tick && (st == S_SETUP ||
                              (st == S_HIGH && !(slot_end && (last || frame_q))));
  wire             in_a     = (single_q && laneb_q) ? sdo_b : sdo_a;
  wire [BITS-1:0]  word_a   = {sh_a[BITS-2:0], in_a};
  wire [BITS-1:0]  word_b   = {sh_b[BITS-2:0], sdo_b};
  wire             word_end = (bitc == BW'(BITS - 1));
  wire [SW:0]      rsum     = {1'b0, slot} + (SW+1)'(HALF_CH);
  wire [IW-1:0]    rot      = IW'((rsum >= (SW+1)'(NCH)) ? rsum - (SW+1)'(NCH) : rsum);
  wire [IW-1:0]    idx_a    = (single_q && laneb_q) ? rot : IW'(slot);
  wire [IW-1:0]    idx_b    = IW'(slot + SW'(HALF_CH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cs_n <= 1'b1; sclk <= 1'b1; done <= 1'b0; corrupt <= 1'b0;
      align_err <= 1'b0; err_q <= 1'b0; busy_q <= 1'b0; cnt <= '0;
      half_q <= DIV_W'(1); single_q <= 1'b0; laneb_q <= 1'b0; frame_q <= 1'b0;
      bitc <= '0; slot <= '0; sh_a <= '0; sh_b <= '0; ch_data <= '0;
      for (int i = 0; i < NCH; i++) stage[i] <= '0;
    end else begin
      busy_q  <= busy;
      done    <= 1'b0;
      corrupt <= 1'b0;
      if (st != S_IDLE) cnt <= tick ? '0 : cnt + 1'b1;
      if (st != S_IDLE && bfall) begin
        st <= S_REST; cs_n <= 1'b1; sclk <= 1'b1; cnt <= '0; corrupt <= 1'b1;
      end else begin
        if (do_samp) begin
          st <= S_LOW; sclk <= 1'b0;
          sh_a <= word_a; sh_b <= word_b;
          if (first_flag != (slot == '0)) err_q <= 1'b1;
          if (word_end) begin
            bitc <= '0;
            slot <= slot + 1'b1;
            stage[idx_a] <= word_a;
            if (!single_q) stage[idx_b] <= word_b;
          end else begin
            bitc <= bitc + 1'b1;
          end
        end
        case (st)
          S_IDLE: if (start) begin
            half_q   <= (cfg_half == '0) ? DIV_W'(1) : cfg_half;
            single_q <= cfg_single; laneb_q <= cfg_lane_b; frame_q <= cfg_frame_each;
            st <= S_SETUP; cs_n <= 1'b0; cnt <= '0;
            bitc <= '0; slot <= '0; err_q <= 1'b0;
          end
          S_REST: if (tick) begin
            st <= S_SETUP; cs_n <= 1'b0; bitc <= '0; slot <= '0; err_q <= 1'b0;
          end
          S_GAP: if (tick) begin
            st <= S_SETUP; cs_n <= 1'b0;
          end
          S_LOW: if (tick) begin
            st <= S_HIGH; sclk <= 1'b1;
          end
          S_HIGH: if (tick && slot_end && last) begin
            st <= S_IDLE; cs_n <= 1'b1; done <= 1'b1; align_err <= err_q;
            for (int i = 0; i < NCH; i++) ch_data[i*BITS +: BITS] <= stage[i];
          end else if (tick && slot_end && frame_q) begin
            st <= S_GAP; cs_n <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module adc_capture_ctrl_chk #(
  parameter int BITS = 18,
  parameter int NCH  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n,
  input logic                sclk,
  input logic                done,
  input logic                corrupt,
  input logic                align_err,
  input logic [NCH*BITS-1:0] ch_data
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ch_data));
  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  assert_corrupt_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    corrupt |-> cs_n);
  assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(align_err));
endmodule

bind adc_capture_ctrl adc_capture_ctrl_chk #(.BITS(BITS), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .done(done),
  .corrupt(corrupt), .align_err(align_err), .ch_data(ch_data)
);

// File: tb/sim_adc_capture_ctrl.sv
module sim_adc_capture_ctrl;
  localparam int BITS = 18;
  localparam int NCH  = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, busy = 1'b0;
  logic sdo_a = 1'b0, sdo_b = 1'b0, first_flag = 1'b0;
  logic cfg_single = 1'b0, cfg_lane_b = 1'b0, cfg_frame_each = 1'b0;
  logic [7:0] cfg_half = 8'd1;
  wire cs_n, sclk, done, align_err, corrupt;
  wire [NCH*BITS-1:0] ch_data;

  always #10 clk = ~clk;

  adc_capture_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .sdo_a(sdo_a), .sdo_b(sdo_b),
    .first_flag(first_flag), .cfg_single(cfg_single), .cfg_lane_b(cfg_lane_b),
    .cfg_frame_each(cfg_frame_each), .cfg_half(cfg_half), .cs_n(cs_n), .sclk(sclk),
    .done(done), .align_err(align_err), .corrupt(corrupt), .ch_data(ch_data)
  );

  int total = 0, bad = 0;

  // converter model
  logic [BITS-1:0] cur [NCH];
  logic [BITS-1:0] nxt [NCH];
  int p = 0, fc = 0;
  bit pend = 0, sclk_p = 1, busy_p = 0, cs_p = 1, flag_stuck = 0;

  function automatic logic dbit(input int lane, input int pp);
    int sl, ch;
    sl = pp / BITS;
    if (sl >= NCH) return 1'b0;
    ch = lane ? (sl + NCH/2) % NCH : sl;
    return cur[ch][BITS-1 - (pp % BITS)];
  endfunction

  always @(sclk or busy or cs_n) begin
    if (busy_p && !busy) begin
      pend = 1;
      for (int i = 0; i < NCH; i++) cur[i] = nxt[i];
    end
    if (cs_p && !cs_n && pend) begin p = 0; fc = 0; pend = 0; end
    if (!cs_n && sclk && !sclk_p) p++;
    if (!cs_n && !sclk && sclk_p) fc++;
    sclk_p = sclk; busy_p = busy; cs_p = cs_n;
    sdo_a = cs_n ? 1'b0 : dbit(0, p);
    sdo_b = cs_n ? 1'b0 : dbit(1, p);
    first_flag = (cs_n || flag_stuck) ? 1'b0 : (fc < BITS);
  end

  // port monitor
  int cyc = 0, nfalls = 0, ncsf = 0, ndone = 0, ncor = 0, nbad_delay = 0, nbad_int = 0;
  int cs_fall_cyc = 0, last_fall = 0;
  bit cs_q = 1, sclk_q = 1, wait_first = 0, have_fall = 0;
  int heff;
  assign heff = (cfg_half == 0) ? 1 : int'(cfg_half);

  always @(negedge clk) begin
    cyc++;
    if (cs_q && !cs_n) begin ncsf++; cs_fall_cyc = cyc; wait_first = 1; have_fall = 0; end
    if (!cs_q && cs_n) have_fall = 0;
    if (sclk_q && !sclk) begin
      nfalls++;
      if (wait_first) begin
        if (cyc - cs_fall_cyc < heff) nbad_delay++;
        wait_first = 0;
      end
      if (have_fall && (cyc - last_fall != 2*heff)) nbad_int++;
      have_fall = 1; last_fall = cyc;
    end
    if (done) ndone++;
    if (corrupt) ncor++;
    cs_q = cs_n; sclk_q = sclk;
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [BITS-1:0] pat(input int seed, input int ch);
    logic [31:0] t;
    t = seed * 32'h9E37 + ch * 32'h2F1B3 + (ch << 15);
    if (ch == 0) t = t | 32'h20001;
    return t[BITS-1:0];
  endfunction

  task automatic check_data(input string req);
    for (int ch = 0; ch < NCH; ch++)
      check(req, $sformatf("channel %0d word", ch + 1), 32'(ch_data[ch*BITS +: BITS]), 32'(cur[ch]));
  endtask

  int d_falls, d_csf, d_done, d_cor, d_bdel, d_bint;

  task automatic xfer(input bit single, input bit laneb, input bit frame, input logic [7:0] half,
                      input int seed, input bit abort);
    int f0, c0, n0, r0, bd0, bi0, guard;
    logic [NCH*BITS-1:0] prev;
    cfg_single = single; cfg_lane_b = laneb; cfg_frame_each = frame; cfg_half = half;
    for (int i = 0; i < NCH; i++) nxt[i] = pat(seed, i);
    @(negedge clk) busy = 1'b1;
    repeat (3) @(negedge clk);
    busy = 1'b0;
    repeat (2) @(negedge clk);
    f0 = nfalls; c0 = ncsf; n0 = ndone; r0 = ncor; bd0 = nbad_delay; bi0 = nbad_int;
    prev = ch_data;
    if (abort) busy = 1'b1;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (abort) begin
      guard = 0;
      while (nfalls - f0 < 20 && guard < 5000) begin @(negedge clk); guard++; end
      check("R9", "words hold during transfer", 32'(ch_data == prev), 32'd1);
      for (int i = 0; i < NCH; i++) nxt[i] = pat(seed + 100, i);
      busy = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    check("R9", "done seen", 32'(done), 32'd1);
    check("R9", "cs_n high with done", 32'(cs_n), 32'd1);
    repeat (3) @(negedge clk);
    d_falls = nfalls - f0; d_csf = ncsf - c0; d_done = ndone - n0;
    d_cor = ncor - r0; d_bdel = nbad_delay - bd0; d_bint = nbad_int - bi0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "cs_n in reset", 32'(cs_n), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "cs_n", 32'(cs_n), 32'd1);
    check("R1", "sclk", 32'(sclk), 32'd1);
    check("R1", "done", 32'(done), 32'd0);
    check("R1", "align_err", 32'(align_err), 32'd0);
    check("R1", "corrupt", 32'(corrupt), 32'd0);
    check("R1", "ch_data zero", 32'(ch_data == '0), 32'd1);
  endtask

  task automatic t_dual();
    xfer(0, 0, 0, 8'd2, 1, 0);
    check_data("R2");
    check("R2", "sclk falls", 32'(d_falls), 32'd72);
    check("R5", "cs falls held", 32'(d_csf), 32'd1);
    check("R8", "cs to sclk delay violations", 32'(d_bdel), 32'd0);
    check("R8", "sclk period violations", 32'(d_bint), 32'd0);
    check("R9", "done cycles", 32'(d_done), 32'd1);
    check("R6", "align_err clean", 32'(align_err), 32'd0);
  endtask

  task automatic t_single_a();
    xfer(1, 0, 1, 8'd1, 2, 0);
    check_data("R3");
    check("R3", "sclk falls", 32'(d_falls), 32'd144);
    check("R5", "cs falls per word, one lane", 32'(d_csf), 32'd8);
    check("R8", "sclk period violations", 32'(d_bint), 32'd0);
    check("R6", "align_err framed", 32'(align_err), 32'd0);
  endtask

  task automatic t_single_b();
    xfer(1, 1, 0, 8'd3, 3, 0);
    check_data("R4");
    check("R4", "sclk falls", 32'(d_falls), 32'd144);
    check("R5", "cs falls held", 32'(d_csf), 32'd1);
    check("R6", "align_err lane b", 32'(align_err), 32'd0);
  endtask

  task automatic t_dual_framed();
    xfer(0, 0, 1, 8'd2, 4, 0);
    check_data("R2");
    check("R5", "cs falls per word, two lanes", 32'(d_csf), 32'd4);
    check("R8", "cs to sclk delay violations", 32'(d_bdel), 32'd0);
  endtask

  task automatic t_half_zero();
    xfer(0, 0, 0, 8'd0, 5, 0);
    check_data("R8");
    check("R8", "half 0 period violations", 32'(d_bint), 32'd0);
    check("R8", "half 0 delay violations", 32'(d_bdel), 32'd0);
  endtask

  task automatic t_align();
    flag_stuck = 1;
    xfer(0, 0, 0, 8'd1, 6, 0);
    check("R6", "align_err on stuck flag", 32'(align_err), 32'd1);
    flag_stuck = 0;
    xfer(0, 0, 0, 8'd1, 7, 0);
    check("R6", "align_err clears", 32'(align_err), 32'd0);
  endtask

  task automatic t_abort();
    xfer(0, 0, 0, 8'd2, 8, 1);
    check("R7", "corrupt pulses", 32'(d_cor), 32'd1);
    check_data("R7");
    check("R7", "align_err after restart", 32'(align_err), 32'd0);
    check("R9", "done cycles after restart", 32'(d_done), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin cur[i] = '0; nxt[i] = '0; end
    t_reset();
    t_dual();
    t_single_a();
    t_single_b();
    t_dual_framed();
    t_half_zero();
    t_align();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end
endmodule